// File: doc/BRIEF.md
# Two-Phase Programmable FIR with Block Padding

This block filters one radar pulse of real samples. Samples arrive one per handshake, and the first sample of a pulse carries a start marker. The block steers even-indexed samples into one delay line and odd-indexed samples into a second delay line. Both phases use one shared set of run-time coefficients and one shared run-time tap count.

Each time an odd sample is accepted, the block emits one output beat. The beat carries the even-phase result and the odd-phase result side by side. In this way the two phases are interleaved again, and each beat can serve as an I/Q pair for a downstream FFT. After the last pair of a pulse, the block appends zero beats until the pulse fills a fixed power-of-two block. The last beat of the block is flagged as end-of-block.

Coefficient and tap-count writes use a small write port. A write that arrives while a pulse is in flight is held in a one-entry slot. It takes effect once the pulse has been fully emitted.

Top module: `polyphase_fir_pad`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `cfg_ready`=1. All coefficients reset to zero and the tap count resets to 8, so a pulse sent with no configuration yields all-zero beats.
- R2: A pulse is 4064 samples, and sample 0 has `in_sop`=1. Beat k (k < 2032) has even result `e[k]` in `out_data[15:0]` and odd result `o[k]` in `out_data[31:16]`. Here `e[k]=Σ c[j]·x[2(k-j)]` and `o[k]=Σ c[j]·x[2(k-j)+1]` for j < tap count.
- R3: Both delay lines restart from zero at each start-of-pulse. A sample with index below zero counts as 0, whatever the previous pulse held.
- R4: A write with `cfg_is_taps`=1 sets the tap count to `cfg_data`, clamped to the range 8..48. A write with `cfg_is_taps`=0 stores signed `cfg_data` as coefficient `c[cfg_addr]`.
- R5: Each lane is `(acc + 2^14) >>> 15`, saturated to the signed 16-bit range [-32768, 32767].
- R6: Beats 2032 to 2047 of each pulse are zero. `out_eob`=1 on beat 2047 and on no other beat, giving exactly 2048 beats per pulse.
- R7: A configuration write accepted during a pulse does not affect that pulse. `cfg_ready` stays 0 while the write is held, and the write applies once the last beat of the pulse has been loaded.
- R8: Between pulses, samples with `in_sop`=0 are consumed and discarded. They produce no output and do not change the next pulse.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_eob` hold steady. Back-pressure loses no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| in_data | input | 16 | Signed real sample |
| in_sop | input | 1 | Marks the first sample of a pulse |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Low while a held write is pending |
| cfg_is_taps | input | 1 | 1: tap count write, 0: coefficient write |
| cfg_addr | input | 6 | Coefficient index |
| cfg_data | input | 16 | Coefficient (signed) or tap count (unsigned) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 32 | {odd lane, even lane}, signed 16 bits each |
| out_eob | output | 1 | Last beat of the 2048-beat block |

## Verification
A pair beat is due one cycle after its odd sample is accepted, because the dot products feed one output register. Zero beats then follow at one per cycle while the downstream is ready. A held configuration write becomes visible as `cfg_ready` rising one cycle after the final beat is loaded. The bench never predicts a beat by cycle count. Instead, it records each beat on the falling edge where `out_valid` and `out_ready` are both high, and it compares that beat against a reference model computed from the requirements. It reads `cfg_ready` on falling edges after a write has completed its handshake.

// File: rtl/polyphase_fir_pad.sv
module polyphase_fir_pad #(
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int OW        = 16,
  parameter int SHIFT     = 15,
  parameter int PULSE_LEN = 4064,
  parameter int BLOCK_LEN = 2048,
  parameter int MIN_TAPS  = 8,
  parameter int MAX_TAPS  = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DW-1:0]       in_data,
  input  logic                in_sop,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic                cfg_is_taps,
  input  logic [$clog2(MAX_TAPS)-1:0] cfg_addr,
  input  logic [CW-1:0]       cfg_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*OW-1:0]     out_data,
  output logic                out_eob
);
  localparam int TAW  = $clog2(MAX_TAPS);
  localparam int NW   = $clog2(MAX_TAPS + 1);
  localparam int AccW = DW + CW + $clog2(MAX_TAPS) + 1;
  localparam int SW   = $clog2(PULSE_LEN);
  localparam int BW   = $clog2(BLOCK_LEN);
  localparam logic signed [AccW-1:0] HALF = AccW'(1) << (SHIFT - 1);
  localparam logic signed [AccW-1:0] SMAX = AccW'((1 << (OW - 1)) - 1);
  localparam logic signed [AccW-1:0] SMIN = -AccW'(1 << (OW - 1));

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAD} state_t;

  state_t st;
  logic signed [CW-1:0] coef  [MAX_TAPS];
  logic signed [DW-1:0] eline [MAX_TAPS];
  logic signed [DW-1:0] oline [MAX_TAPS];
  logic signed [DW-1:0] enew  [MAX_TAPS];
  logic signed [DW-1:0] onew  [MAX_TAPS];
  logic [NW-1:0] taps;
  logic [SW-1:0] scnt;
  logic [BW-1:0] bcnt;
  logic          pv, p_is_taps;
  logic [TAW-1:0] p_addr;
  logic [CW-1:0]  p_data;
  logic signed [AccW-1:0] acc_e, acc_o;
  logic busy;

  function automatic logic signed [OW-1:0] rsat(input logic signed [AccW-1:0] a);
    logic signed [AccW-1:0] r;
    r = (a + HALF) >>> SHIFT;
    if (r > SMAX) r = SMAX;
    else if (r < SMIN) r = SMIN;
    return r[OW-1:0];
  endfunction

  wire out_free  = !out_valid || out_ready;
  assign busy    = (st != S_IDLE);
  assign in_ready = (st == S_IDLE) || (st == S_RUN && (!scnt[0] || out_free));
  wire in_fire   = in_valid && in_ready;
  wire sop_fire  = in_fire && st == S_IDLE && in_sop;
  wire run_fire  = in_fire && st == S_RUN;
  wire pair_fire = run_fire && scnt[0];
  wire pad_load  = st == S_PAD && out_free;
  wire last_beat = bcnt == BW'(BLOCK_LEN - 1);

  assign cfg_ready = !pv;
  wire cfg_fire  = cfg_valid && cfg_ready;
  wire w_en      = st == S_IDLE && (pv || cfg_fire);
  wire w_is_taps = pv ? p_is_taps : cfg_is_taps;
  wire [TAW-1:0] w_addr = pv ? p_addr : cfg_addr;
  wire [CW-1:0]  w_data = pv ? p_data : cfg_data;

  always_comb begin
    acc_e = '0;
    acc_o = '0;
    for (int j = 0; j < MAX_TAPS; j++) begin
      enew[j] = (j == 0) ? $signed(in_data) : eline[(j == 0) ? 0 : j - 1];
      onew[j] = (j == 0) ? $signed(in_data) : oline[(j == 0) ? 0 : j - 1];
      if (NW'(j) < taps) begin
        acc_e = acc_e + coef[j] * eline[j];
        acc_o = acc_o + coef[j] * onew[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      scnt      <= '0;
      bcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eob   <= 1'b0;
      taps      <= NW'(MIN_TAPS);
      pv        <= 1'b0;
      p_is_taps <= 1'b0;
      p_addr    <= '0;
      p_data    <= '0;
      for (int j = 0; j < MAX_TAPS; j++) begin
        coef[j]  <= '0;
        eline[j] <= '0;
        oline[j] <= '0;
      end
    end else begin
      if (pair_fire || pad_load) out_valid <= 1'b1;
      else if (out_ready)        out_valid <= 1'b0;

      if (sop_fire) begin
        for (int j = 0; j < MAX_TAPS; j++) begin
          eline[j] <= (j == 0) ? $signed(in_data) : '0;
          oline[j] <= '0;
        end
        scnt <= SW'(1);
        bcnt <= '0;
        st   <= S_RUN;
      end else if (run_fire) begin
        if (scnt[0]) oline <= onew;
        else         eline <= enew;
        scnt <= scnt + SW'(1);
      end

      if (pair_fire) begin
        out_data <= {rsat(acc_o), rsat(acc_e)};
        out_eob  <= last_beat;
        bcnt     <= bcnt + BW'(1);
        if (scnt == SW'(PULSE_LEN - 1)) st <= last_beat ? S_IDLE : S_PAD;
      end

      if (pad_load) begin
        out_data <= '0;
        out_eob  <= last_beat;
        bcnt     <= bcnt + BW'(1);
        if (last_beat) st <= S_IDLE;
      end

      if (w_en) begin
        pv <= 1'b0;
        if (w_is_taps) begin
          if (w_data < CW'(MIN_TAPS))      taps <= NW'(MIN_TAPS);
          else if (w_data > CW'(MAX_TAPS)) taps <= NW'(MAX_TAPS);
          else                             taps <= w_data[NW-1:0];
        end else if (w_addr < TAW'(MAX_TAPS)) begin
          coef[w_addr] <= $signed(w_data);
        end
      end else if (cfg_fire) begin
        pv        <= 1'b1;
        p_is_taps <= cfg_is_taps;
        p_addr    <= cfg_addr;
        p_data    <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/poly_fir_chk.sv
module poly_fir_chk #(
  parameter int OW       = 16,
  parameter int NW       = 6,
  parameter int MIN_TAPS = 8,
  parameter int MAX_TAPS = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2*OW-1:0] out_data,
  input logic          out_eob,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic          busy,
  input logic [NW-1:0] taps
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && cfg_ready && !busy); // R1
  AST_TAPS_RANGE: assert property (@(posedge clk) disable iff (rst)
    taps >= NW'(MIN_TAPS) && taps <= NW'(MAX_TAPS)); // R4
  AST_EOB_PADDED: assert property (@(posedge clk) disable iff (rst)
    out_eob && out_valid |-> out_data == '0); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_ready && busy |=> !cfg_ready); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eob)); // R9
endmodule

bind polyphase_fir_pad poly_fir_chk #(
  .OW(OW), .NW(NW), .MIN_TAPS(MIN_TAPS), .MAX_TAPS(MAX_TAPS)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_eob(out_eob), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .busy(busy), .taps(taps)
);

// File: tb/sim_polyphase_fir_pad.sv
module sim_polyphase_fir_pad;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4064;
  localparam int NP = NS / 2;
  localparam int NB = 2048;
  localparam int MT = 48;
  localparam int NCASE = 5;
  localparam int CASE_TAPS [NCASE] = '{8, 48, 3, 60, 48};
  localparam int CASE_CSEL [NCASE] = '{0, 1, 2, 0, 1};
  localparam int CASE_XSEL [NCASE] = '{0, 1, 2, 3, 2};
  localparam int CASE_BP   [NCASE] = '{0, 0, 1, 0, 1};

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sop = 0;
  logic [15:0] in_data = 0;
  logic in_ready, cfg_ready, out_valid, out_eob;
  logic cfg_valid = 0, cfg_is_taps = 0;
  logic [5:0] cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic out_ready = 0;
  logic [31:0] out_data;

  int tests = 0, fails = 0;
  longint xs [NS];
  longint cs [MT];
  int ntap = 8;
  int lane_err, pad_err, eob_err;

  polyphase_fir_pad u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_is_taps(cfg_is_taps), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eob(out_eob)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gen_c(int sel, int j);
    case (sel)
      0: return longint'((j * 1103 + 517) % 4096) - 2048;
      1: return 32767;
      default: return (j % 2 == 0) ? longint'(j * 600) : -longint'(j * 600);
    endcase
  endfunction

  function automatic longint gen_x(int sel, int i);
    case (sel)
      0: return longint'((i * 37) % 2001) - 1000;
      1: return 32767;
      2: return (i % 3 == 0) ? -32768 : longint'(12345 * (i % 5)) - 20000;
      default: return -32768;
    endcase
  endfunction

  function automatic int clampt(int t);
    return (t < 8) ? 8 : (t > MT) ? MT : t;
  endfunction

  function automatic longint model(int p, int m);
    longint acc = 0, r;
    for (int j = 0; j < ntap; j++)
      if (m - j >= 0) acc += cs[j] * xs[2 * (m - j) + p];
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic cfg_write(input bit is_t, input int addr, input int data);
    cfg_valid = 1; cfg_is_taps = is_t; cfg_addr = 6'(addr); cfg_data = 16'(data);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    @(posedge clk); #1;
    cfg_valid = 0;
  endtask

  task automatic send_pulse();
    for (int i = 0; i < NS; i++) begin
      in_valid = 1; in_data = 16'(xs[i]); in_sop = (i == 0);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 0; in_sop = 0;
  endtask

  task automatic collect(input bit bp);
    int beats = 0, rc = 0;
    lane_err = 0; pad_err = 0; eob_err = 0;
    while (beats < NB) begin
      @(posedge clk); #1;
      out_ready = bp ? (rc % 3 != 0) : 1'b1;
      rc++;
      @(negedge clk);
      if (out_valid && out_ready) begin
        if (beats < NP) begin
          if ($signed(out_data[15:0]) != model(0, beats) ||
              $signed(out_data[31:16]) != model(1, beats)) begin
            if (lane_err == 0)
              $display("  beat %0d even=%0d/%0d odd=%0d/%0d", beats,
                $signed(out_data[15:0]), model(0, beats), $signed(out_data[31:16]), model(1, beats));
            lane_err++;
          end
        end else if (out_data != 0) pad_err++;
        if (out_eob != (beats == NB - 1)) eob_err++;
        beats++;
      end
    end
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic run_pulse(input bit bp, input string req);
    fork
      send_pulse();
      collect(bp);
    join
    chk(lane_err == 0, req, lane_err, 0);
    chk(pad_err == 0, "R6 pad zero", pad_err, 0);
    chk(eob_err == 0, "R6 eob position", eob_err, 0);
  endtask

  task automatic load_case(input int t, input int csel);
    ntap = clampt(t);
    cfg_write(1, 0, t);
    for (int j = 0; j < MT; j++) begin
      cs[j] = gen_c(csel, j);
      cfg_write(0, j, int'(cs[j]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < MT; j++) cs[j] = 0;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(cfg_ready == 1, "R1 cfg_ready", cfg_ready, 1);
    @(posedge clk); #1;

    // R1: zero coefficients after reset
    for (int i = 0; i < NS; i++) xs[i] = gen_x(0, i);
    run_pulse(0, "R1 reset coef zero");

    // Table walk: R2 lanes, R3 fresh history per pulse, R4 clamp, R5 saturation, R9 bp
    for (int k = 0; k < NCASE; k++) begin
      load_case(CASE_TAPS[k], CASE_CSEL[k]);
      for (int i = 0; i < NS; i++) xs[i] = gen_x(CASE_XSEL[k], i);
      run_pulse(CASE_BP[k] != 0, $sformatf("R2 R3 R4 R5 R9 case %0d", k));
    end

    // R8: non-sop samples between pulses are discarded
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = 16'(30000 - i); in_sop = 0;
      @(negedge clk);
      chk(in_ready == 1, "R8 idle consume", in_ready, 1);
      @(posedge clk); #1;
    end
    in_valid = 0;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 0, "R8 no output", out_valid, 0);
    end
    @(posedge clk); #1;
    for (int i = 0; i < NS; i++) xs[i] = gen_x(0, i);
    run_pulse(0, "R8 pulse after discard");

    // R7: write during a pulse is held until the pulse ends
    load_case(16, 0);
    fork
      send_pulse();
      collect(1);
      begin
        repeat (200) @(posedge clk);
        #1;
        cfg_write(1, 0, 8);
        @(negedge clk);
        chk(cfg_ready == 0, "R7 held write blocks", cfg_ready, 0);
      end
    join
    chk(lane_err == 0, "R7 old taps in pulse", lane_err, 0);
    chk(pad_err == 0, "R6 pad zero", pad_err, 0);
    chk(eob_err == 0, "R6 eob position", eob_err, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(cfg_ready == 1, "R7 applied after pulse", cfg_ready, 1);
    @(posedge clk); #1;
    ntap = 8;
    run_pulse(0, "R7 new taps next pulse");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule